// File: doc/BRIEF.md
# Sampled Input Noise Filter Bank

This block cleans up five asynchronous timer input pins before any edge logic sees them. Channels 0 to 3 are the four capture/compare inputs (A, B, C and D in that order). Channel 4 is the trigger input. Each pin first passes through a two-flop synchronizer.

In filtered mode, the synchronized level is sampled only on a selectable sampling strobe. The clean level moves to a new value only once three strobe-spaced samples in a row agree. In bypass mode, the synchronized level is used directly. The chosen level drives a per-channel edge detector that emits one-cycle rise and fall pulses.

The sampling strobe is picked by a shared 2-bit rate field. Three of its codes select fixed prescaler taps. The fourth code selects the timer count source, which a separate 3-bit field chooses. All sources arrive as single-cycle clock-enable ticks in the one system clock domain. The prescaler, the timer counter and the capture/compare logic sit outside this block.

Rate, source and enable settings are captured together on a strobe of the currently active source. A change therefore never takes effect between sampling points.

Top module: `noise_filter_bank`

## Requirements
- R1: While reset is asserted and directly after it, every clean level, rise pulse and fall pulse is 0.
- R2: In filtered mode a channel's clean level changes only at a sampling strobe, and only to a value that the last three strobe samples of the synchronized pin all hold.
- R3: A pin pulse that is seen by only one or two consecutive strobe samples is treated as noise: the clean level holds and no edge pulse appears.
- R4: From a pin change to the filtered level change, no more than five sampling strobes pass. With the every-cycle strobe, the change shows up on the fifth clock edge after the pin moves.
- R5: The rate field `samp_sel_i` uses these codes: 2'b00 selects the divide-by-32 tick, 2'b01 the divide-by-8 tick, 2'b10 every clock cycle, and 2'b11 the timer count source.
- R6: The count-source field `cnt_sel_i` uses these codes: 3'b000 every clock cycle, 3'b001 divide-by-2, 3'b010 divide-by-4, 3'b011 divide-by-8, 3'b100 divide-by-32, 3'b101 external clock tick, 3'b110 fast oscillator tick, 3'b111 alternate oscillator tick.
- R7: Bit i of `filt_en_i` set to 1 selects the filtered level for channel i. Set to 0, it passes the synchronized pin level, which follows the pin two clock edges later. Other channels are unaffected.
- R8: Each level transition of a channel gives exactly one pulse, one clock wide, on `rise_o` (for 0 to 1) or on `fall_o` (for 1 to 0), in the same cycle as the new level.
- R9: New settings on `samp_sel_i`, `cnt_sel_i` and `filt_en_i` take effect only at the next strobe of the source that is active at that moment. The reset setting is code 00 with all channels in bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 5 | Raw asynchronous pins: bits 0-3 capture/compare A-D, bit 4 trigger |
| samp_sel_i | input | 2 | Sampling-rate select (R5) |
| cnt_sel_i | input | 3 | Timer count-source select (R6) |
| filt_en_i | input | 5 | Per-channel filter enable, 1 = filtered |
| tick_div2_i | input | 1 | Divide-by-2 prescaler tick |
| tick_div4_i | input | 1 | Divide-by-4 prescaler tick |
| tick_div8_i | input | 1 | Divide-by-8 prescaler tick |
| tick_div32_i | input | 1 | Divide-by-32 prescaler tick |
| tick_ext_i | input | 1 | External clock pin tick |
| tick_fast_osc_i | input | 1 | Fast on-chip oscillator tick |
| tick_alt_osc_i | input | 1 | Alternate on-chip oscillator tick |
| level_o | output | 5 | Clean level per channel |
| rise_o | output | 5 | One-cycle rising-edge pulse per channel |
| fall_o | output | 5 | One-cycle falling-edge pulse per channel |

## Verification
The assertions rely on two assumptions about the inputs. Every tick input is a single-cycle enable that is synchronous to `clk`. The configuration inputs are sampled only on a strobe, so the assertions reason about the captured copies rather than the raw fields. The bench builds all ticks from one free-running counter, so each tick is high for exactly one cycle out of its period. It changes the configuration only while the pins are steady, and then waits longer than the slowest strobe period before measuring anything. Pins are driven on the falling clock edge, so every transition has a defined first synchronizer edge from which latencies are counted.

// File: rtl/nf_pkg.sv
package nf_pkg;

    typedef enum logic [1:0] {
        SS_DIV32  = 2'b00,
        SS_DIV8   = 2'b01,
        SS_FULL   = 2'b10,
        SS_CNTSRC = 2'b11
    } samp_sel_e;

    typedef enum logic [2:0] {
        CS_F1    = 3'b000,
        CS_F2    = 3'b001,
        CS_F4    = 3'b010,
        CS_F8    = 3'b011,
        CS_F32   = 3'b100,
        CS_EXT   = 3'b101,
        CS_FAST  = 3'b110,
        CS_ALT   = 3'b111
    } cnt_sel_e;

endpackage

// File: rtl/nf_sync.sv
module nf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic meta_o,
    output logic lvl_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign meta_o = st_q.chain[0];
    assign lvl_o  = st_q.chain[STAGES-1];

endmodule

// File: rtl/nf_strobe_mux.sv
module nf_strobe_mux
    import nf_pkg::*;
#(
    parameter int NUM_CH = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        samp_sel_i,
    input  logic [2:0]        cnt_sel_i,
    input  logic [NUM_CH-1:0] filt_en_i,
    input  logic              tick_div2_i,
    input  logic              tick_div4_i,
    input  logic              tick_div8_i,
    input  logic              tick_div32_i,
    input  logic              tick_ext_i,
    input  logic              tick_fast_osc_i,
    input  logic              tick_alt_osc_i,
    output logic              strobe_o,
    output logic [NUM_CH-1:0] en_q_o,
    output logic [1:0]        samp_q_o
);

    typedef struct packed {
        logic [1:0]        samp;
        logic [2:0]        csrc;
        logic [NUM_CH-1:0] en;
    } state_t;

    state_t st_d, st_q;
    logic   cnt_tick;
    logic   stb;

    always_comb begin
        unique case (cnt_sel_e'(st_q.csrc))
            CS_F1:   cnt_tick = 1'b1;
            CS_F2:   cnt_tick = tick_div2_i;
            CS_F4:   cnt_tick = tick_div4_i;
            CS_F8:   cnt_tick = tick_div8_i;
            CS_F32:  cnt_tick = tick_div32_i;
            CS_EXT:  cnt_tick = tick_ext_i;
            CS_FAST: cnt_tick = tick_fast_osc_i;
            CS_ALT:  cnt_tick = tick_alt_osc_i;
            default: cnt_tick = 1'b0;
        endcase

        unique case (samp_sel_e'(st_q.samp))
            SS_DIV32:  stb = tick_div32_i;
            SS_DIV8:   stb = tick_div8_i;
            SS_FULL:   stb = 1'b1;
            SS_CNTSRC: stb = cnt_tick;
            default:   stb = 1'b0;
        endcase

        st_d = st_q;
        if (stb) begin
            st_d.samp = samp_sel_i;
            st_d.csrc = cnt_sel_i;
            st_d.en   = filt_en_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe_o = stb;
    assign en_q_o   = st_q.en;
    assign samp_q_o = st_q.samp;

endmodule

// File: rtl/nf_channel.sv
module nf_channel #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic filt_en_i,
    input  logic sync_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [DEPTH-1:0] smp;
        logic             flt;
        logic             prev;
    } state_t;

    state_t st_d, st_q;
    logic   sel_lvl;

    always_comb begin
        st_d    = st_q;
        sel_lvl = filt_en_i ? st_q.flt : sync_i;

        if (strobe_i) begin
            st_d.smp = {st_q.smp[DEPTH-2:0], sync_i};
            // look ahead at the window including this sample
            if (&st_d.smp)       st_d.flt = 1'b1;
            else if (~|st_d.smp) st_d.flt = 1'b0;
        end

        st_d.prev = sel_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = sel_lvl;
    assign rise_o  = sel_lvl & ~st_q.prev;
    assign fall_o  = ~sel_lvl & st_q.prev;

endmodule

// File: rtl/noise_filter_bank.sv
module noise_filter_bank
    import nf_pkg::*;
#(
    parameter int NUM_CH      = 5,
    parameter int SYNC_STAGES = 2,
    parameter int MATCH_DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pin_i,
    input  logic [1:0]        samp_sel_i,
    input  logic [2:0]        cnt_sel_i,
    input  logic [NUM_CH-1:0] filt_en_i,
    input  logic              tick_div2_i,
    input  logic              tick_div4_i,
    input  logic              tick_div8_i,
    input  logic              tick_div32_i,
    input  logic              tick_ext_i,
    input  logic              tick_fast_osc_i,
    input  logic              tick_alt_osc_i,
    output logic [NUM_CH-1:0] level_o,
    output logic [NUM_CH-1:0] rise_o,
    output logic [NUM_CH-1:0] fall_o
);

    logic              strobe;
    logic [NUM_CH-1:0] en_q;
    logic [1:0]        samp_q;
    logic [NUM_CH-1:0] syn_meta;
    logic [NUM_CH-1:0] syn_lvl;

    nf_strobe_mux #(.NUM_CH(NUM_CH)) u_strobe (
        .clk             (clk),
        .rst_n           (rst_n),
        .samp_sel_i      (samp_sel_i),
        .cnt_sel_i       (cnt_sel_i),
        .filt_en_i       (filt_en_i),
        .tick_div2_i     (tick_div2_i),
        .tick_div4_i     (tick_div4_i),
        .tick_div8_i     (tick_div8_i),
        .tick_div32_i    (tick_div32_i),
        .tick_ext_i      (tick_ext_i),
        .tick_fast_osc_i (tick_fast_osc_i),
        .tick_alt_osc_i  (tick_alt_osc_i),
        .strobe_o        (strobe),
        .en_q_o          (en_q),
        .samp_q_o        (samp_q)
    );

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        nf_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_i[gi]),
            .meta_o (syn_meta[gi]),
            .lvl_o  (syn_lvl[gi])
        );

        nf_channel #(.DEPTH(MATCH_DEPTH)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .strobe_i  (strobe),
            .filt_en_i (en_q[gi]),
            .sync_i    (syn_lvl[gi]),
            .level_o   (level_o[gi]),
            .rise_o    (rise_o[gi]),
            .fall_o    (fall_o[gi])
        );
    end

endmodule

// File: rtl/nf_checker.sv
module nf_checker #(
    parameter int NUM_CH = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe,
    input logic [NUM_CH-1:0] en_q,
    input logic [1:0]        samp_q,
    input logic [NUM_CH-1:0] meta,
    input logic [NUM_CH-1:0] sync,
    input logic [NUM_CH-1:0] level,
    input logic [NUM_CH-1:0] rise,
    input logic [NUM_CH-1:0] fall
);

    // R5
    full_rate_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_q == 2'b10) |-> strobe);

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chk
        // R2
        filt_change_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en_q[gi] && $past(en_q[gi]) && !$stable(level[gi])) |-> $past(strobe));

        // R2
        filt_change_matches_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en_q[gi] && $past(en_q[gi]) && !$stable(level[gi])) |-> (level[gi] == $past(sync[gi])));

        // R7
        bypass_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_q[gi] && $past(!en_q[gi])) |-> (level[gi] == $past(meta[gi])));

        // R8
        rise_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise[gi] |=> !rise[gi]);

        // R8
        fall_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fall[gi] |=> !fall[gi]);
    end

endmodule

bind noise_filter_bank nf_checker #(.NUM_CH(NUM_CH)) u_nf_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .en_q   (en_q),
    .samp_q (samp_q),
    .meta   (syn_meta),
    .sync   (syn_lvl),
    .level  (level_o),
    .rise   (rise_o),
    .fall   (fall_o)
);

// File: tb/noise_filter_bank_bench.sv
module noise_filter_bank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 5;
    localparam int P_EXT      = 5;
    localparam int P_FAST     = 3;
    localparam int P_ALT      = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] pin_i = '0;
    logic [1:0]     samp_sel_i = 2'b00;
    logic [2:0]     cnt_sel_i = 3'b000;
    logic [NCH-1:0] filt_en_i = '0;
    logic [NCH-1:0] level_o, rise_o, fall_o;
    int unsigned    cnt = 0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cnt <= cnt + 1;

    wire t2   = (cnt % 2)  == 1;
    wire t4   = (cnt % 4)  == 3;
    wire t8   = (cnt % 8)  == 7;
    wire t32  = (cnt % 32) == 31;
    wire text = (cnt % P_EXT)  == P_EXT - 1;
    wire tfst = (cnt % P_FAST) == P_FAST - 1;
    wire talt = (cnt % P_ALT)  == P_ALT - 1;

    noise_filter_bank u_noise_filter_bank (
        .clk             (clk),
        .rst_n           (rst_n),
        .pin_i           (pin_i),
        .samp_sel_i      (samp_sel_i),
        .cnt_sel_i       (cnt_sel_i),
        .filt_en_i       (filt_en_i),
        .tick_div2_i     (t2),
        .tick_div4_i     (t4),
        .tick_div8_i     (t8),
        .tick_div32_i    (t32),
        .tick_ext_i      (text),
        .tick_fast_osc_i (tfst),
        .tick_alt_osc_i  (talt),
        .level_o         (level_o),
        .rise_o          (rise_o),
        .fall_o          (fall_o)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi,
                               input string what);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    function automatic int period_of(input logic [1:0] ss, input logic [2:0] cs);
        case (ss)
            2'b00: return 32;
            2'b01: return 8;
            2'b10: return 1;
            default: case (cs)
                3'b000: return 1;
                3'b001: return 2;
                3'b010: return 4;
                3'b011: return 8;
                3'b100: return 32;
                3'b101: return P_EXT;
                3'b110: return P_FAST;
                default: return P_ALT;
            endcase
        endcase
    endfunction

    task automatic configure(input logic [1:0] ss, input logic [2:0] cs, input logic [NCH-1:0] en);
        @(negedge clk);
        samp_sel_i = ss;
        cnt_sel_i  = cs;
        filt_en_i  = en;
        repeat (150) @(negedge clk);
    endtask

    // R1
    task automatic t_reset();
        @(negedge clk);
        check("R1", int'(level_o), 0, "level in reset");
        check("R1", int'(rise_o | fall_o), 0, "pulses in reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", int'(level_o), 0, "level after reset");
    endtask

    // R2 R4 R5 R6 R8: steady change, latency window derived from strobe period
    task automatic t_latency(input int ch, input logic [1:0] ss, input logic [2:0] cs,
                             input logic lvl, input string req);
        int p, n, rc, fc;
        p = period_of(ss, cs);
        n = 0; rc = 0; fc = 0;
        pin_i[ch] = lvl;
        while (n < 400) begin
            @(negedge clk);
            n++;
            if (rise_o[ch]) rc++;
            if (fall_o[ch]) fc++;
            if (level_o[ch] == lvl) break;
        end
        check_range(req, n, 2*p + 3, 3*p + 2, "latency window");
        check_range("R4", n, 1, 5*p, "latency within five strobes");
        check("R8", rc, lvl ? 1 : 0, "rise pulse count");
        check("R8", fc, lvl ? 0 : 1, "fall pulse count");
        repeat (2) @(negedge clk);
        check("R8", int'(rise_o[ch] | fall_o[ch]), 0, "pulse cleared");
    endtask

    // R3
    task automatic t_glitch(input int ch, input int width);
        int rc;
        rc = 0;
        pin_i[ch] = 1'b1;
        repeat (width) @(negedge clk);
        pin_i[ch] = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (rise_o[ch] || level_o[ch]) rc++;
        end
        check("R3", rc, 0, $sformatf("glitch of %0d cycles ignored", width));
    endtask

    // R7
    task automatic t_bypass();
        int nb, nf;
        nb = 0; nf = 0;
        pin_i[2] = 1'b1;
        pin_i[0] = 1'b1;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            if (nb == 0 && level_o[2]) nb = i;
            if (nf == 0 && level_o[0]) nf = i;
        end
        check("R7", nb, 2, "bypass latency");
        check("R7", nf, 5, "filtered neighbour latency");
        pin_i[2] = 1'b0;
        pin_i[0] = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    // R9
    task automatic t_cfg_timing();
        configure(2'b00, 3'b000, 5'b01000);
        while ((cnt % 32) != 2) @(negedge clk);
        filt_en_i[3] = 1'b0;
        pin_i[3] = 1'b1;
        repeat (12) @(negedge clk);
        check("R9", int'(level_o[3]), 0, "old setting still filtering");
        repeat (30) @(negedge clk);
        check("R9", int'(level_o[3]), 1, "bypass after next strobe");
        pin_i[3] = 1'b0;
        repeat (10) @(negedge clk);
        check("R9", int'(level_o[3]), 0, "bypass follows pin");
    endtask

    initial begin
        t_reset();

        configure(2'b10, 3'b000, 5'b11111);
        t_latency(0, 2'b10, 3'b000, 1'b1, "R5");
        t_latency(0, 2'b10, 3'b000, 1'b0, "R5");
        t_glitch(1, 1);
        t_glitch(1, 2);
        t_glitch(4, 2);
        t_bypass_prep();

        configure(2'b01, 3'b000, 5'b11111);
        t_latency(4, 2'b01, 3'b000, 1'b1, "R5");
        t_latency(4, 2'b01, 3'b000, 1'b0, "R5");
        t_glitch(2, 16);

        configure(2'b00, 3'b000, 5'b11111);
        t_latency(1, 2'b00, 3'b000, 1'b1, "R5");
        t_latency(1, 2'b00, 3'b000, 1'b0, "R5");

        for (int cs = 0; cs < 8; cs++) begin
            configure(2'b11, 3'(cs), 5'b11111);
            t_latency(3, 2'b11, 3'(cs), 1'b1, "R6");
            t_latency(3, 2'b11, 3'(cs), 1'b0, "R6");
        end

        t_cfg_timing();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic t_bypass_prep();
        configure(2'b10, 3'b000, 5'b11011);
        t_bypass();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule